// File: doc/BRIEF.md
# Instruction Breakpoint Match Unit

This block stores two instruction breakpoints and checks every fetch address against them. Software writes each breakpoint as a 32-bit word. Bit 0 of the word turns the breakpoint on. The upper bits hold the address that should stop execution. That address is used exactly as written. The block adds no process identifier to it, so software stores the address already in its final modified form.

The compare depends on the width of the instruction being fetched. For 32-bit instructions only the word address counts. For 16-bit compressed instructions the halfword address counts. When an enabled breakpoint matches a valid fetch and global debug is on, the block raises a break request in that same cycle. The pipeline can then take the debug exception before the instruction executes.

One cycle later the block shows a 3-bit method-of-entry code and a per-register hit status. These are used by the exception logic.

Top module: `ibkpt_unit`

## Requirements
- R1: Two 32-bit breakpoint registers are written through `reg_wr_en`/`reg_wr_sel`/`reg_wr_data`. Register 0 is selected by select value 0 and register 1 by select value 1. `reg_rd_data` returns the selected register combinationally with all 32 bits as written, including bit 1.
- R2: Bit 0 of a register is its enable (1 = armed, 0 = off). A register with bit 0 clear never produces a hit.
- R3: After reset both enable bits read 0, and no fetch causes a break until a register is written.
- R4: When `fetch_half` is 0 (32-bit instruction mode), a register hits when bits 31:2 of the fetch address equal bits 31:2 of the register. Address bits 1:0 and register bit 1 are ignored.
- R5: When `fetch_half` is 1 (16-bit instruction mode), a register hits when bits 31:1 of the fetch address equal bits 31:1 of the register. Address bit 0 is ignored.
- R6: `brk_req` is combinational. It is high in the same cycle as a fetch with `fetch_valid` = 1 that hits. It is never high while `fetch_valid` is 0.
- R7: While `dbg_global_en` is 0, `brk_req` stays low even when an enabled register matches.
- R8: In the cycle after a break request, `entry_code` reads 3'b001. In the cycle after any cycle without a break request, it reads 3'b000.
- R9: `hit_status` is registered alongside `entry_code`. Bit 0 marks a hit on register 0 and bit 1 marks a hit on register 1. When both match, it reads 2'b01 (register 0 wins). It reads 2'b00 after a cycle without a break request.
- R10: A register write affects fetches from the next cycle onward. A fetch in the same cycle as the write is compared with the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dbg_global_en | input | 1 | Global debug enable |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_sel | input | 1 | Register index for writes |
| reg_wr_data | input | 32 | Write data: address in 31:1, enable in bit 0 |
| reg_rd_sel | input | 1 | Register index for reads |
| reg_rd_data | output | 32 | Selected register contents |
| fetch_valid | input | 1 | Fetch address is valid this cycle |
| fetch_addr | input | 32 | Fetch address |
| fetch_half | input | 1 | 1 = 16-bit instruction mode, 0 = 32-bit mode |
| brk_req | output | 1 | Break request, same cycle as the fetch |
| entry_code | output | 3 | Registered method-of-entry code |
| hit_status | output | 2 | Registered one-hot winning register |

## Verification
The stored breakpoint carries bit 1 set. Word-mode fetches at the base address and at base+2 must both hit, while a halfword-mode fetch at the base address must miss. This separates the two compare widths.

Fetches that differ only in bit 0 confirm that bit 0 is never compared. Fetches at a neighbouring word confirm that real mismatches are rejected.

The same matching address is also tried with the fetch strobe low, with global debug off, with the register disabled, and with both registers holding it. These cases isolate the qualification and priority paths.

A write issued in the same cycle as a fetch of the new address shows that the old value is used until the next cycle.

// File: rtl/ibkpt_pkg.sv
// Package: shared sizes and method-of-entry codes for the breakpoint unit.
// Assumes a single instruction-breakpoint entry reason.
package ibkpt_pkg;
    parameter int unsigned IB_XLEN = 32;
    parameter int unsigned IB_NUM  = 2;

    typedef logic [2:0] moe_t;

    localparam moe_t MOE_NONE  = 3'b000;
    localparam moe_t MOE_IBKPT = 3'b001;
endpackage

// File: rtl/ibkpt_regfile.sv
// Module: breakpoint register storage.
// Keeps NUM registers of XLEN bits. Only the enable bits are reset; the
// address fields start undefined. Writes land on the clock edge, and the
// read port is combinational.
module ibkpt_regfile #(
    parameter int XLEN = 32,
    parameter int NUM  = 2,
    localparam int SEL_W = (NUM > 1) ? $clog2(NUM) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [SEL_W-1:0]          wr_sel,
    input  logic [XLEN-1:0]           wr_data,
    input  logic [SEL_W-1:0]          rd_sel,
    output logic [XLEN-1:0]           rd_data,
    output logic [NUM-1:0][XLEN-1:0]  bp_regs
);
    logic [NUM-1:0]            en_q;
    logic [NUM-1:0][XLEN-1:1]  addr_q;

    for (genvar i = 0; i < NUM; i++) begin : g_reg
        logic sel_hit;
        assign sel_hit = wr_en && (wr_sel == SEL_W'(i));

        // Enable bit: cleared by reset, loaded on write.
        always_ff @(posedge clk) begin
            if (!rst_n)       en_q[i] <= 1'b0;
            else if (sel_hit) en_q[i] <= wr_data[0];
        end

        // Address field: no reset, loaded on write.
        always_ff @(posedge clk) begin
            if (sel_hit) addr_q[i] <= wr_data[XLEN-1:1];
        end

        assign bp_regs[i] = {addr_q[i], en_q[i]};
    end

    // Read mux: full stored word of the selected register.
    always_comb rd_data = bp_regs[rd_sel];
endmodule

// File: rtl/ibkpt_compare.sv
// Module: per-register address comparators.
// A register hits when it is enabled and its address equals the fetch
// address under a mode mask. Bit 0 is never compared. Bit 1 is compared
// only in 16-bit mode. Purely combinational.
module ibkpt_compare #(
    parameter int XLEN = 32,
    parameter int NUM  = 2
) (
    input  logic [NUM-1:0][XLEN-1:0] bp_regs,
    input  logic [XLEN-1:0]          fetch_addr,
    input  logic                     fetch_half,
    output logic [NUM-1:0]           hit
);
    logic [XLEN-1:0] cmp_mask;

    // Mode mask: upper bits always, bit 1 only in 16-bit mode.
    always_comb cmp_mask = {{(XLEN-2){1'b1}}, fetch_half, 1'b0};

    for (genvar i = 0; i < NUM; i++) begin : g_cmp
        // Masked equality, gated by this register's enable bit.
        always_comb
            hit[i] = bp_regs[i][0] && (((fetch_addr ^ bp_regs[i]) & cmp_mask) == '0);
    end
endmodule

// File: rtl/ibkpt_arbiter.sv
// Module: qualification, priority and registered report.
// The break request is combinational. The entry code and the one-hot hit
// status are registered one cycle later. The lowest-numbered register wins.
module ibkpt_arbiter
    import ibkpt_pkg::*;
#(
    parameter int NUM = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NUM-1:0] hit,
    input  logic           fetch_valid,
    input  logic           dbg_global_en,
    output logic           brk_req,
    output moe_t           entry_code,
    output logic [NUM-1:0] hit_status
);
    logic [NUM-1:0] winner;

    // Qualify: valid fetch, debug globally on, and at least one hit.
    always_comb brk_req = fetch_valid && dbg_global_en && (|hit);

    // Priority: isolate the lowest set bit of the hit vector.
    always_comb winner = hit & (~hit + NUM'(1));

    // Report register: code and winner for the cycle just finished.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            entry_code <= MOE_NONE;
            hit_status <= '0;
        end else begin
            entry_code <= brk_req ? MOE_IBKPT : MOE_NONE;
            hit_status <= brk_req ? winner : '0;
        end
    end
endmodule

// File: rtl/ibkpt_unit.sv
// Module: instruction breakpoint match unit (top).
// Connects register storage, mode-masked comparators and the priority and
// report stage. Stored addresses are used exactly as written.
module ibkpt_unit
    import ibkpt_pkg::*;
#(
    parameter int XLEN = IB_XLEN,
    parameter int NUM  = IB_NUM,
    localparam int SEL_W = (NUM > 1) ? $clog2(NUM) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dbg_global_en,
    input  logic             reg_wr_en,
    input  logic [SEL_W-1:0] reg_wr_sel,
    input  logic [XLEN-1:0]  reg_wr_data,
    input  logic [SEL_W-1:0] reg_rd_sel,
    output logic [XLEN-1:0]  reg_rd_data,
    input  logic             fetch_valid,
    input  logic [XLEN-1:0]  fetch_addr,
    input  logic             fetch_half,
    output logic             brk_req,
    output logic [2:0]       entry_code,
    output logic [NUM-1:0]   hit_status
);
    logic [NUM-1:0][XLEN-1:0] bp_regs;
    logic [NUM-1:0]           hit;

    ibkpt_regfile #(.XLEN(XLEN), .NUM(NUM)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_wr_en),
        .wr_sel  (reg_wr_sel),
        .wr_data (reg_wr_data),
        .rd_sel  (reg_rd_sel),
        .rd_data (reg_rd_data),
        .bp_regs (bp_regs)
    );

    ibkpt_compare #(.XLEN(XLEN), .NUM(NUM)) u_cmp (
        .bp_regs    (bp_regs),
        .fetch_addr (fetch_addr),
        .fetch_half (fetch_half),
        .hit        (hit)
    );

    ibkpt_arbiter #(.NUM(NUM)) u_arb (
        .clk           (clk),
        .rst_n         (rst_n),
        .hit           (hit),
        .fetch_valid   (fetch_valid),
        .dbg_global_en (dbg_global_en),
        .brk_req       (brk_req),
        .entry_code    (entry_code),
        .hit_status    (hit_status)
    );
endmodule

// File: rtl/ibkpt_unit_chk.sv
// Module: assertion checker for ibkpt_unit, attached by bind.
// Watches only the top-level ports.
module ibkpt_unit_chk #(
    parameter int NUM = 2
) (
    input logic           clk,
    input logic           rst_n,
    input logic           fetch_valid,
    input logic           dbg_global_en,
    input logic           brk_req,
    input logic [2:0]     entry_code,
    input logic [NUM-1:0] hit_status
);
    AST_BRK_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        brk_req |-> fetch_valid); // R6
    AST_BRK_NEEDS_GLOBAL: assert property (@(posedge clk) disable iff (!rst_n)
        brk_req |-> dbg_global_en); // R7
    AST_CODE_AFTER_BRK: assert property (@(posedge clk) disable iff (!rst_n)
        brk_req |=> (entry_code == 3'b001)); // R8
    AST_CODE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !brk_req |=> (entry_code == 3'b000)); // R8
    AST_STATUS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_status)); // R9
    AST_STATUS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !brk_req |=> (hit_status == '0)); // R9
endmodule

bind ibkpt_unit ibkpt_unit_chk #(.NUM(NUM)) u_chk (.*);

// File: tb/ibkpt_unit_tb.sv
// Scoreboard bench for ibkpt_unit. A driver task applies one cycle of
// stimulus, checks brk_req at once and queues the expected registered
// report. A monitor pops each item after the next edge and compares.
module ibkpt_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dbg_global_en = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic        reg_wr_sel = 1'b0;
    logic [31:0] reg_wr_data = '0;
    logic        reg_rd_sel = 1'b0;
    logic [31:0] reg_rd_data;
    logic        fetch_valid = 1'b0;
    logic [31:0] fetch_addr = '0;
    logic        fetch_half = 1'b0;
    logic        brk_req;
    logic [2:0]  entry_code;
    logic [1:0]  hit_status;

    typedef struct {
        logic [2:0] code;
        logic [1:0] status;
        string      tag;
    } exp_t;

    exp_t        sb_q[$];
    logic [31:0] mreg [2];
    int          n_chk = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    always #2 clk = ~clk;

    ibkpt_unit u_dut (
        .clk(clk), .rst_n(rst_n), .dbg_global_en(dbg_global_en),
        .reg_wr_en(reg_wr_en), .reg_wr_sel(reg_wr_sel), .reg_wr_data(reg_wr_data),
        .reg_rd_sel(reg_rd_sel), .reg_rd_data(reg_rd_data),
        .fetch_valid(fetch_valid), .fetch_addr(fetch_addr), .fetch_half(fetch_half),
        .brk_req(brk_req), .entry_code(entry_code), .hit_status(hit_status)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Reference model built from the requirements.
    task automatic model(input logic fv, input logic [31:0] fa, input logic fh,
                         input logic ge, output logic b, output logic [1:0] st);
        logic [1:0] h;
        logic [31:0] m;
        m = fh ? 32'hFFFF_FFFE : 32'hFFFF_FFFC;
        for (int i = 0; i < 2; i++)
            h[i] = mreg[i][0] && ((fa & m) == (mreg[i] & m));
        b  = fv && ge && (h != 2'b00);
        st = !b ? 2'b00 : (h[0] ? 2'b01 : 2'b10);
    endtask

    task automatic step(input logic wr, input logic wsel, input logic [31:0] wdata,
                        input logic fv, input logic [31:0] fa, input logic fh,
                        input logic ge, input string tag);
        exp_t e;
        logic b;
        logic [1:0] st;
        @(negedge clk);
        reg_wr_en = wr; reg_wr_sel = wsel; reg_wr_data = wdata;
        fetch_valid = fv; fetch_addr = fa; fetch_half = fh; dbg_global_en = ge;
        model(fv, fa, fh, ge, b, st);
        e.code = b ? 3'b001 : 3'b000;
        e.status = st;
        e.tag = tag;
        sb_q.push_back(e);
        #1;
        check(brk_req === b, {tag, " brk_req"}, 32'(brk_req), 32'(b));
        if (wr) mreg[wsel] = wdata;
    endtask

    task automatic rd_chk(input logic sel, input logic [31:0] mask,
                          input logic [31:0] exp, input string tag);
        step(1'b0, 1'b0, '0, 1'b0, '0, 1'b0, 1'b1, tag);
        reg_rd_sel = sel;
        #0.5;
        check((reg_rd_data & mask) === exp, {tag, " read"}, reg_rd_data & mask, exp);
    endtask

    // Monitor: registered report appears after the edge following the push.
    always @(posedge clk) begin
        if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            #1;
            check(entry_code === e.code, {e.tag, " entry_code"},
                  32'(entry_code), 32'(e.code));
            check(hit_status === e.status, {e.tag, " hit_status"},
                  32'(hit_status), 32'(e.status));
        end
    end

    initial begin
        #400000;
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        mreg[0] = '0; mreg[1] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R3: enables clear after reset, no break.
        rd_chk(1'b0, 32'h1, 32'h0, "R3 reg0 enable");
        rd_chk(1'b1, 32'h1, 32'h0, "R3 reg1 enable");
        step(0, 0, '0, 1, 32'h0, 0, 1, "R3 fetch after reset");
        // R1: write with bit 1 set, full readback.
        step(1, 0, 32'h0000_1003, 0, '0, 0, 1, "R1 write reg0");
        rd_chk(1'b0, 32'hFFFF_FFFF, 32'h0000_1003, "R1 reg0");
        // R4: word mode ignores register bit 1 and fetch bits 1:0.
        step(0, 0, '0, 1, 32'h0000_1000, 0, 1, "R4 word base");
        step(0, 0, '0, 1, 32'h0000_1002, 0, 1, "R4 word base+2");
        step(0, 0, '0, 1, 32'h0000_1004, 0, 1, "R4 word next");
        // R5: halfword mode compares bit 1.
        step(0, 0, '0, 1, 32'h0000_1002, 1, 1, "R5 half match");
        step(0, 0, '0, 1, 32'h0000_1003, 1, 1, "R5 half bit0 ignored");
        step(0, 0, '0, 1, 32'h0000_1000, 1, 1, "R5 half mismatch");
        // R6 and R7: qualification.
        step(0, 0, '0, 0, 32'h0000_1000, 0, 1, "R6 no valid");
        step(0, 0, '0, 1, 32'h0000_1000, 0, 0, "R7 global off");
        // R9: register 1 alone, then R2 disable.
        step(1, 1, 32'h0000_2001, 0, '0, 0, 1, "R1 write reg1");
        rd_chk(1'b1, 32'hFFFF_FFFF, 32'h0000_2001, "R1 reg1");
        step(0, 0, '0, 1, 32'h0000_2000, 0, 1, "R9 reg1 hit");
        step(1, 1, 32'h0000_2000, 0, '0, 0, 1, "R2 disable reg1");
        step(0, 0, '0, 1, 32'h0000_2000, 0, 1, "R2 disabled no hit");
        // R9: both match, register 0 wins.
        step(1, 0, 32'h0000_3001, 0, '0, 0, 1, "R9 set reg0");
        step(1, 1, 32'h0000_3001, 0, '0, 0, 1, "R9 set reg1");
        step(0, 0, '0, 1, 32'h0000_3000, 0, 1, "R9 both hit");
        // R10: write and fetch in one cycle uses old value.
        step(1, 0, 32'h0000_4001, 1, 32'h0000_4000, 0, 1, "R10 same cycle");
        step(0, 0, '0, 1, 32'h0000_4000, 0, 1, "R10 next cycle");
        step(0, 0, '0, 0, '0, 0, 1, "R8 idle");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule